// File: doc/BRIEF.md
# Pending Invalidation Ack Tracker

This block holds the bookkeeping for one outstanding transaction on a shared L2 line. A strobe opens the entry whenever the line needs invalidations sent or a fill fetched. At that moment the entry captures three values from the line: how many L1 caches share it, whether its data is dirty, and the transaction state to start in. While the entry is open, acknowledgements arrive carrying signed counts. Each count is subtracted from the pending total. The block reports, in the same cycle as the ack, whether that ack completes the set or is an intermediate one.

The entry also remembers who is waiting for a reply. Load requestors are kept as a bit set with one bit per L1. The single store requestor is kept as an ID. From the load set the block derives whether an exclusive-data reply is allowed and whether a shared-data reply is allowed. Write-back data from an L1 updates the held dirty flag.

An effective-state output merges the transaction state with the line state from the tag array. The transaction state takes precedence. Two sticky error flags catch misuse:
- stimulus that arrives while the entry is closed;
- ack counts that would drive the total out of range.

Top module: `inval_ack_tracker`

## Requirements
- R1: A cycle with `alloc_i` high opens the entry on the next edge, taking precedence over `dealloc_i` and over every update in that cycle. Opening sets `busy_o`, loads `pending_o` with `snap_sharers_i`, copies `snap_dirty_i` into `dirty_o` and `snap_state_i` into the transaction state, and clears the load set and the store record.
- R2: While the entry is open, an ack whose result is in range replaces `pending_o` with `pending_o - ack_count_i` on the next edge. `ack_count_i` is two's complement, so a negative count raises the total. With no ack, allocate or deallocate, `pending_o` holds.
- R3: While the entry is open, an ack asserts exactly one of `ack_last_o` or `ack_mid_o`, combinationally in the same cycle. `ack_last_o` is asserted when `pending_o - ack_count_i` equals zero. `ack_mid_o` is asserted when the result is in range and nonzero.
- R4: While the entry is open, `load_req_i` sets bit `load_id_i` of `load_set_o`, and bits accumulate. `store_req_i` stores `store_id_i` in `store_id_o` and sets `store_rec_o`.
- R5: `excl_ok_o` is high exactly when one bit of `load_set_o` is set. `shared_ok_o` is high when at least one bit is set.
- R6: `eff_state_o` shows the transaction state while the entry is open. Otherwise it shows `line_state_i` when `tag_hit_i` is high. Otherwise it shows code 0, which means not present.
- R7: While the entry is open, `wb_valid_i` overwrites the dirty flag with `wb_dirty_i`: 1 for a dirty write-back, 0 for a clean one.
- R8: While the entry is closed, `ack_valid_i`, `load_req_i`, `store_req_i`, `wb_valid_i` or `state_wr_i` sets the sticky `misuse_err_o` and changes no other state. No ack pulse is produced in that case.
- R9: An ack whose result is negative or above the largest pending value sets the sticky `count_err_o`. Such an ack leaves `pending_o` unchanged and raises neither `ack_last_o` nor `ack_mid_o`.
- R10: `dealloc_i` without `alloc_i` closes the entry on the next edge. Closing clears the pending total, the load set, the store record, the dirty flag and the transaction state. Updates arriving in the same cycle are discarded, but the ack classification of that cycle is still reported.
- R11: While the entry is open, `state_wr_i` replaces the transaction state with `state_val_i`.
- R12: After reset the entry is closed, every register is zero and both error flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alloc_i | input | 1 | Open the entry |
| dealloc_i | input | 1 | Close the entry |
| snap_sharers_i | input | PEND_W | Sharer count captured on open |
| snap_dirty_i | input | 1 | Dirty flag captured on open |
| snap_state_i | input | STATE_W | Initial transaction state |
| ack_valid_i | input | 1 | Ack arriving this cycle |
| ack_count_i | input | ACK_W | Signed count carried by the ack |
| load_req_i | input | 1 | Record a load requestor |
| load_id_i | input | ID_W | Load requestor ID |
| store_req_i | input | 1 | Record the store requestor |
| store_id_i | input | ID_W | Store requestor ID |
| wb_valid_i | input | 1 | Write-back data from an L1 |
| wb_dirty_i | input | 1 | Write-back is dirty (1) or clean (0) |
| state_wr_i | input | 1 | Write the transaction state |
| state_val_i | input | STATE_W | New transaction state |
| tag_hit_i | input | 1 | Line present in the tag array |
| line_state_i | input | STATE_W | State held in the tag array |
| busy_o | output | 1 | Entry open |
| pending_o | output | PEND_W | Acks still expected |
| ack_mid_o | output | 1 | Current ack is intermediate |
| ack_last_o | output | 1 | Current ack completes the set |
| load_set_o | output | NUM_L1 | Waiting load requestors |
| store_rec_o | output | 1 | Store requestor recorded |
| store_id_o | output | ID_W | Store requestor ID |
| excl_ok_o | output | 1 | Exclusive-data reply allowed |
| shared_ok_o | output | 1 | Shared-data reply allowed |
| dirty_o | output | 1 | Held dirty flag |
| eff_state_o | output | STATE_W | Effective line state |
| misuse_err_o | output | 1 | Sticky: stimulus while closed |
| count_err_o | output | 1 | Sticky: ack result out of range |

## Verification
Ack classification can fall in the same cycle as an allocate or a deallocate. The bench provokes this by driving both strobes together with acks, requestor records, write-backs and state writes, first in directed steps and then in a long pseudo-random run. The model keeps the ack pulse computed from the pre-edge total and lets the allocate or deallocate discard the update, so that a wrong priority shows up in `pending_o`, `load_set_o` or `dirty_o` one cycle later. Misuse in the same cycle as an allocate is judged the same way: the flag must rise while the fresh snapshot still loads.

// File: rtl/ait_pkg.sv
package ait_pkg;

    typedef enum logic [1:0] {
        ACK_NONE  = 2'd0,
        ACK_MID   = 2'd1,
        ACK_LAST  = 2'd2,
        ACK_RANGE = 2'd3
    } ack_class_e;

endpackage

// File: rtl/ait_ack_counter.sv
module ait_ack_counter #(
    parameter int PEND_W = 5,
    parameter int ACK_W  = PEND_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_i,
    input  logic                     clear_i,
    input  logic [PEND_W-1:0]        load_val_i,
    input  logic                     ack_en_i,
    input  logic signed [ACK_W-1:0]  ack_cnt_i,
    output logic [PEND_W-1:0]        pending_o,
    output ait_pkg::ack_class_e      ack_class_o,
    output logic                     range_err_o
);
    import ait_pkg::*;

    localparam int DIFF_W = ACK_W + 2;
    localparam logic signed [DIFF_W-1:0] PEND_MAX =
        {{(DIFF_W-PEND_W){1'b0}}, {PEND_W{1'b1}}};

    typedef struct packed {
        logic [PEND_W-1:0] pend;
        logic              err;
    } cnt_state_t;

    cnt_state_t cur_q, nxt_d;
    logic signed [DIFF_W-1:0] diff;
    ack_class_e cls;

    always_comb begin
        nxt_d = cur_q;
        diff  = $signed({{(DIFF_W-PEND_W){1'b0}}, cur_q.pend})
              - $signed({{(DIFF_W-ACK_W){ack_cnt_i[ACK_W-1]}}, ack_cnt_i});
        cls   = ACK_NONE;
        if (ack_en_i) begin
            if (diff < 0 || diff > PEND_MAX) begin
                cls        = ACK_RANGE;
                nxt_d.err  = 1'b1;
            end else if (diff == 0) begin
                cls = ACK_LAST;
            end else begin
                cls = ACK_MID;
            end
        end
        if (load_i) begin
            nxt_d.pend = load_val_i;
        end else if (clear_i) begin
            nxt_d.pend = '0;
        end else if (cls == ACK_LAST || cls == ACK_MID) begin
            nxt_d.pend = diff[PEND_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign pending_o   = cur_q.pend;
    assign range_err_o = cur_q.err;
    assign ack_class_o = cls;

endmodule

// File: rtl/ait_req_record.sv
module ait_req_record #(
    parameter int NUM_L1 = 8,
    parameter int ID_W   = (NUM_L1 > 1) ? $clog2(NUM_L1) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              clear_i,
    input  logic              ld_en_i,
    input  logic [ID_W-1:0]   ld_id_i,
    input  logic              st_en_i,
    input  logic [ID_W-1:0]   st_id_i,
    output logic [NUM_L1-1:0] load_set_o,
    output logic              store_rec_o,
    output logic [ID_W-1:0]   store_id_o,
    output logic              excl_ok_o,
    output logic              shared_ok_o
);
    localparam int CNT_W = $clog2(NUM_L1 + 1);

    typedef struct packed {
        logic [NUM_L1-1:0] set;
        logic              srec;
        logic [ID_W-1:0]   sid;
    } rec_state_t;

    rec_state_t cur_q, nxt_d;
    logic [CNT_W-1:0] ones;

    always_comb begin
        nxt_d = cur_q;
        if (load_i || clear_i) begin
            nxt_d = '0;
        end else begin
            for (int i = 0; i < NUM_L1; i++) begin
                if (ld_en_i && int'(ld_id_i) == i) nxt_d.set[i] = 1'b1;
            end
            if (st_en_i) begin
                nxt_d.srec = 1'b1;
                nxt_d.sid  = st_id_i;
            end
        end
    end

    always_comb begin
        ones = '0;
        for (int i = 0; i < NUM_L1; i++) begin
            ones = ones + CNT_W'(cur_q.set[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign load_set_o  = cur_q.set;
    assign store_rec_o = cur_q.srec;
    assign store_id_o  = cur_q.sid;
    assign excl_ok_o   = (ones == CNT_W'(1));
    assign shared_ok_o = (ones != '0);

endmodule

// File: rtl/ait_entry_ctl.sv
module ait_entry_ctl #(
    parameter int                  STATE_W  = 3,
    parameter logic [STATE_W-1:0]  NP_STATE = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc_i,
    input  logic               dealloc_i,
    input  logic               snap_dirty_i,
    input  logic [STATE_W-1:0] snap_state_i,
    input  logic               any_req_i,
    input  logic               wb_valid_i,
    input  logic               wb_dirty_i,
    input  logic               state_wr_i,
    input  logic [STATE_W-1:0] state_val_i,
    input  logic               tag_hit_i,
    input  logic [STATE_W-1:0] line_state_i,
    output logic               busy_o,
    output logic               dirty_o,
    output logic [STATE_W-1:0] eff_state_o,
    output logic               misuse_o
);
    typedef struct packed {
        logic               busy;
        logic               dirty;
        logic [STATE_W-1:0] txn;
        logic               mis;
    } ctl_state_t;

    ctl_state_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (!cur_q.busy && any_req_i) nxt_d.mis = 1'b1;
        if (alloc_i) begin
            nxt_d.busy  = 1'b1;
            nxt_d.dirty = snap_dirty_i;
            nxt_d.txn   = snap_state_i;
        end else if (dealloc_i) begin
            nxt_d.busy  = 1'b0;
            nxt_d.dirty = 1'b0;
            nxt_d.txn   = '0;
        end else if (cur_q.busy) begin
            if (wb_valid_i) nxt_d.dirty = wb_dirty_i;
            if (state_wr_i) nxt_d.txn   = state_val_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    always_comb begin
        if (cur_q.busy)     eff_state_o = cur_q.txn;
        else if (tag_hit_i) eff_state_o = line_state_i;
        else                eff_state_o = NP_STATE;
    end

    assign busy_o   = cur_q.busy;
    assign dirty_o  = cur_q.dirty;
    assign misuse_o = cur_q.mis;

endmodule

// File: rtl/inval_ack_tracker.sv
module inval_ack_tracker #(
    parameter int                  NUM_L1   = 8,
    parameter int                  STATE_W  = 3,
    parameter logic [STATE_W-1:0]  NP_STATE = '0,
    localparam int ID_W   = (NUM_L1 > 1) ? $clog2(NUM_L1) : 1,
    localparam int PEND_W = $clog2(NUM_L1 + 1) + 1,
    localparam int ACK_W  = PEND_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc_i,
    input  logic               dealloc_i,
    input  logic [PEND_W-1:0]  snap_sharers_i,
    input  logic               snap_dirty_i,
    input  logic [STATE_W-1:0] snap_state_i,
    input  logic               ack_valid_i,
    input  logic [ACK_W-1:0]   ack_count_i,
    input  logic               load_req_i,
    input  logic [ID_W-1:0]    load_id_i,
    input  logic               store_req_i,
    input  logic [ID_W-1:0]    store_id_i,
    input  logic               wb_valid_i,
    input  logic               wb_dirty_i,
    input  logic               state_wr_i,
    input  logic [STATE_W-1:0] state_val_i,
    input  logic               tag_hit_i,
    input  logic [STATE_W-1:0] line_state_i,
    output logic               busy_o,
    output logic [PEND_W-1:0]  pending_o,
    output logic               ack_mid_o,
    output logic               ack_last_o,
    output logic [NUM_L1-1:0]  load_set_o,
    output logic               store_rec_o,
    output logic [ID_W-1:0]    store_id_o,
    output logic               excl_ok_o,
    output logic               shared_ok_o,
    output logic               dirty_o,
    output logic [STATE_W-1:0] eff_state_o,
    output logic               misuse_err_o,
    output logic               count_err_o
);
    import ait_pkg::*;

    logic       busy;
    logic       any_req;
    ack_class_e ack_cls;

    assign any_req = ack_valid_i | load_req_i | store_req_i | wb_valid_i | state_wr_i;

    ait_entry_ctl #(
        .STATE_W  (STATE_W),
        .NP_STATE (NP_STATE)
    ) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_i      (alloc_i),
        .dealloc_i    (dealloc_i),
        .snap_dirty_i (snap_dirty_i),
        .snap_state_i (snap_state_i),
        .any_req_i    (any_req),
        .wb_valid_i   (wb_valid_i),
        .wb_dirty_i   (wb_dirty_i),
        .state_wr_i   (state_wr_i),
        .state_val_i  (state_val_i),
        .tag_hit_i    (tag_hit_i),
        .line_state_i (line_state_i),
        .busy_o       (busy),
        .dirty_o      (dirty_o),
        .eff_state_o  (eff_state_o),
        .misuse_o     (misuse_err_o)
    );

    ait_ack_counter #(
        .PEND_W (PEND_W),
        .ACK_W  (ACK_W)
    ) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (alloc_i),
        .clear_i     (dealloc_i),
        .load_val_i  (snap_sharers_i),
        .ack_en_i    (ack_valid_i & busy),
        .ack_cnt_i   ($signed(ack_count_i)),
        .pending_o   (pending_o),
        .ack_class_o (ack_cls),
        .range_err_o (count_err_o)
    );

    ait_req_record #(
        .NUM_L1 (NUM_L1),
        .ID_W   (ID_W)
    ) u_rec (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (alloc_i),
        .clear_i     (dealloc_i),
        .ld_en_i     (load_req_i & busy),
        .ld_id_i     (load_id_i),
        .st_en_i     (store_req_i & busy),
        .st_id_i     (store_id_i),
        .load_set_o  (load_set_o),
        .store_rec_o (store_rec_o),
        .store_id_o  (store_id_o),
        .excl_ok_o   (excl_ok_o),
        .shared_ok_o (shared_ok_o)
    );

    assign busy_o     = busy;
    assign ack_mid_o  = (ack_cls == ACK_MID);
    assign ack_last_o = (ack_cls == ACK_LAST);

endmodule

// File: rtl/ait_checker.sv
module ait_checker #(
    parameter int                  NUM_L1   = 8,
    parameter int                  STATE_W  = 3,
    parameter logic [STATE_W-1:0]  NP_STATE = '0,
    localparam int PEND_W = $clog2(NUM_L1 + 1) + 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               alloc_i,
    input logic               dealloc_i,
    input logic [PEND_W-1:0]  snap_sharers_i,
    input logic               ack_valid_i,
    input logic               tag_hit_i,
    input logic               busy_o,
    input logic [PEND_W-1:0]  pending_o,
    input logic               ack_mid_o,
    input logic               ack_last_o,
    input logic [NUM_L1-1:0]  load_set_o,
    input logic               excl_ok_o,
    input logic               shared_ok_o,
    input logic [STATE_W-1:0] eff_state_o,
    input logic               misuse_err_o,
    input logic               count_err_o
);
    // R1
    alloc_snapshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |=> (busy_o && pending_o == $past(snap_sharers_i) && load_set_o == '0));

    // R2
    pending_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_valid_i && !alloc_i && !dealloc_i) |=> $stable(pending_o));

    // R3
    ack_pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_last_o && ack_mid_o));

    // R3
    ack_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_last_o || ack_mid_o) |-> (busy_o && ack_valid_i));

    // R5
    excl_implies_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        excl_ok_o |-> shared_ok_o);

    // R6
    idle_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !tag_hit_i) |-> (eff_state_o == NP_STATE));

    // R8
    misuse_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        misuse_err_o |=> misuse_err_o);

    // R9
    count_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_err_o |=> count_err_o);

    // R10
    dealloc_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dealloc_i && !alloc_i) |=> (!busy_o && pending_o == '0));

endmodule

bind inval_ack_tracker ait_checker #(
    .NUM_L1   (NUM_L1),
    .STATE_W  (STATE_W),
    .NP_STATE (NP_STATE)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .alloc_i        (alloc_i),
    .dealloc_i      (dealloc_i),
    .snap_sharers_i (snap_sharers_i),
    .ack_valid_i    (ack_valid_i),
    .tag_hit_i      (tag_hit_i),
    .busy_o         (busy_o),
    .pending_o      (pending_o),
    .ack_mid_o      (ack_mid_o),
    .ack_last_o     (ack_last_o),
    .load_set_o     (load_set_o),
    .excl_ok_o      (excl_ok_o),
    .shared_ok_o    (shared_ok_o),
    .eff_state_o    (eff_state_o),
    .misuse_err_o   (misuse_err_o),
    .count_err_o    (count_err_o)
);

// File: tb/sim_inval_ack_tracker.sv
module sim_inval_ack_tracker;
    localparam int CLK_PERIOD = 10;
    localparam int N   = 8;
    localparam int SW  = 3;
    localparam int IW  = 3;
    localparam int PW  = 5;
    localparam int AW  = 6;
    localparam int PMAX = 31;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alloc, dealloc, sdirty, ackv, ldr, str, wbv, wbd, swr, thit;
    logic [PW-1:0] ssh;
    logic [SW-1:0] sst, sval, lst;
    logic [AW-1:0] acnt;
    logic [IW-1:0] lid, sid;
    logic busy, amid, alast, srec, eok, sok, dirty, merr, cerr;
    logic [PW-1:0] pend;
    logic [N-1:0]  lset;
    logic [IW-1:0] sido;
    logic [SW-1:0] est;

    int checks = 0;
    int errors = 0;

    // reference model state
    bit       m_busy, m_dirty, m_srec, m_mis, m_cerr;
    int       m_pend;
    bit [N-1:0] m_load;
    int       m_sid, m_txn;

    always #(CLK_PERIOD/2) clk = ~clk;

    inval_ack_tracker u0 (
        .clk(clk), .rst_n(rst_n), .alloc_i(alloc), .dealloc_i(dealloc),
        .snap_sharers_i(ssh), .snap_dirty_i(sdirty), .snap_state_i(sst),
        .ack_valid_i(ackv), .ack_count_i(acnt), .load_req_i(ldr), .load_id_i(lid),
        .store_req_i(str), .store_id_i(sid), .wb_valid_i(wbv), .wb_dirty_i(wbd),
        .state_wr_i(swr), .state_val_i(sval), .tag_hit_i(thit), .line_state_i(lst),
        .busy_o(busy), .pending_o(pend), .ack_mid_o(amid), .ack_last_o(alast),
        .load_set_o(lset), .store_rec_o(srec), .store_id_o(sido),
        .excl_ok_o(eok), .shared_ok_o(sok), .dirty_o(dirty), .eff_state_o(est),
        .misuse_err_o(merr), .count_err_o(cerr)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle_inputs();
        alloc = 0; dealloc = 0; ssh = '0; sdirty = 0; sst = '0;
        ackv = 0; acnt = '0; ldr = 0; lid = '0; str = 0; sid = '0;
        wbv = 0; wbd = 0; swr = 0; sval = '0; thit = 0; lst = '0;
    endtask

    function automatic int sx(input logic [AW-1:0] v);
        return int'($signed(v));
    endfunction

    // compare every output against the model, then advance one clock
    task automatic step();
        int  d;
        bit  rng, last, mid;
        int  exp_state;
        #1;
        d    = m_pend - sx(acnt);
        rng  = m_busy && ackv && (d < 0 || d > PMAX);
        last = m_busy && ackv && !rng && d == 0;
        mid  = m_busy && ackv && !rng && d != 0;
        exp_state = m_busy ? m_txn : (thit ? int'(lst) : 0);
        chk("R1/R10 busy", int'(busy), int'(m_busy));
        chk("R2 pending", int'(pend), m_pend);
        chk("R3 last", int'(alast), int'(last));
        chk("R3 mid", int'(amid), int'(mid));
        chk("R4 load_set", int'(lset), int'(m_load));
        chk("R4 store_rec", int'(srec), int'(m_srec));
        chk("R4 store_id", int'(sido), m_sid);
        chk("R5 excl_ok", int'(eok), int'($countones(m_load) == 1));
        chk("R5 shared_ok", int'(sok), int'(m_load != 0));
        chk("R6/R11 eff_state", int'(est), exp_state);
        chk("R7 dirty", int'(dirty), int'(m_dirty));
        chk("R8 misuse", int'(merr), int'(m_mis));
        chk("R9 count_err", int'(cerr), int'(m_cerr));
        @(posedge clk);
        if (!m_busy && (ackv || ldr || str || wbv || swr)) m_mis = 1;
        if (rng) m_cerr = 1;
        if (alloc) begin
            m_busy = 1; m_pend = int'(ssh); m_dirty = sdirty; m_txn = int'(sst);
            m_load = '0; m_srec = 0; m_sid = 0;
        end else if (dealloc) begin
            m_busy = 0; m_pend = 0; m_dirty = 0; m_txn = 0;
            m_load = '0; m_srec = 0; m_sid = 0;
        end else if (m_busy) begin
            if (last || mid) m_pend = d;
            if (ldr) m_load[lid] = 1'b1;
            if (str) begin m_srec = 1; m_sid = int'(sid); end
            if (wbv) m_dirty = wbd;
            if (swr) m_txn = int'(sval);
        end
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle_inputs();
        m_busy = 0; m_dirty = 0; m_srec = 0; m_mis = 0; m_cerr = 0;
        m_pend = 0; m_load = '0; m_sid = 0; m_txn = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12 reset state
        chk("R12 reset busy", int'(busy), 0);
        chk("R12 reset errors", int'(merr | cerr), 0);
        step();

        // R6 line state passes through when closed
        thit = 1; lst = 3'd4; step();
        chk("R6 tag state", int'(est), 4);
        thit = 0;

        // R1 open with three sharers, dirty, state 5
        alloc = 1; ssh = 5'd3; sdirty = 1; sst = 3'd5; step();
        idle_inputs();
        chk("R1 pending snapshot", int'(pend), 3);
        // R3 intermediate then final
        ackv = 1; acnt = 6'd1; step();
        ackv = 1; acnt = 6'd2; #1;
        chk("R3 final ack", int'(alast), 1);
        step();
        chk("R2 pending zero", int'(pend), 0);
        // R2 negative count raises total
        acnt = 6'h3E; step();
        chk("R2 negative ack", int'(pend), 2);
        // R4 / R5 requestors
        ackv = 0; ldr = 1; lid = 3'd2; step();
        chk("R5 exclusive one", int'(eok), 1);
        lid = 3'd5; step();
        chk("R5 two loads", int'(eok), 0);
        ldr = 0; str = 1; sid = 3'd6; step();
        // R7 clean write-back, R11 state write
        str = 0; wbv = 1; wbd = 0; swr = 1; sval = 3'd2; step();
        chk("R7 clean wb", int'(dirty), 0);
        wbv = 0; swr = 0;
        // R9 out of range
        ackv = 1; acnt = 6'd5; step();
        chk("R9 count err", int'(cerr), 1);
        chk("R9 pending kept", int'(pend), 2);
        // R10 close with ack and load in the same cycle
        dealloc = 1; acnt = 6'd2; ldr = 1; lid = 3'd1; step();
        idle_inputs();
        chk("R10 load discarded", int'(lset), 0);
        // R8 misuse while closed
        ldr = 1; lid = 3'd3; step();
        idle_inputs();
        chk("R8 misuse set", int'(merr), 1);
        chk("R8 set untouched", int'(lset), 0);
        step();

        // pseudo-random collisions
        for (int i = 0; i < 3000; i++) begin
            alloc   = ($urandom_range(99) < 8);
            dealloc = ($urandom_range(99) < 6);
            ssh     = PW'($urandom_range(N));
            sdirty  = 1'($urandom_range(1));
            sst     = SW'($urandom_range(7));
            ackv    = ($urandom_range(99) < 40);
            acnt    = AW'($urandom_range(5) - 2);
            ldr     = ($urandom_range(99) < 20);
            lid     = IW'($urandom_range(N-1));
            str     = ($urandom_range(99) < 10);
            sid     = IW'($urandom_range(N-1));
            wbv     = ($urandom_range(99) < 10);
            wbd     = 1'($urandom_range(1));
            swr     = ($urandom_range(99) < 10);
            sval    = SW'($urandom_range(7));
            thit    = 1'($urandom_range(1));
            lst     = SW'($urandom_range(7));
            step();
        end
        idle_inputs();
        step();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule